// File: doc/BRIEF.md
# Spy Buffer Freeze Controller

This block decides when a bank of spy (snapshot) buffers must stop recording. Two kinds of error strobe can start a freeze. The first is a loss-of-synchronization strobe from a monitoring module. The second is an end-event tag mismatch strobe from a bus. When a freeze starts, the buffer write enables are gated off. Whatever history the buffers hold stays in place until software lets recording resume.

Each freeze is tagged with a 2-bit reason code. The code of the first cause is latched and kept. A second controller on a neighbouring device runs the same logic, and the two controllers exchange a four-phase request/acknowledge handshake:

- When a freeze starts locally, the controller sends a request to the peer together with the reason code.
- When the peer sends a request, this controller freezes and acknowledges it.

A release pulse unfreezes the buffers and clears the code. Release is accepted only once both handshakes have returned to rest.

Top module: `spy_freeze_ctrl`

## Requirements
- R1: Each `wr_en_o[i]` equals `wr_req_i[i]` when `frozen_o` is low and no trigger input is high. It is low in any cycle where `frozen_o` is high, any error strobe is high, or `peer_req_i` is high. The gating is combinational, so the trigger cycle itself writes nothing.
- R2: When not frozen, any high bit of `sync_err_i` sets `frozen_o` at the next clock edge with `cause_o` = 2'b01. This has the highest priority.
- R3: When not frozen, any high bit of `eev_err_i` sets `frozen_o` at the next edge with `cause_o` = 2'b10. Sync loss in the same cycle takes precedence.
- R4: When not frozen, a high `peer_req_i` with no local error sets `frozen_o` at the next edge with `cause_o` = 2'b11.
- R5: While frozen, further error strobes and peer requests leave `frozen_o` and `cause_o` unchanged. The first cause is kept.
- R6: A locally caused freeze (code 01 or 10) raises `req_o` in the same cycle as `frozen_o`, with `req_code_o` equal to the cause. `req_o` is held until `peer_ack_i` is high and is low from the following cycle.
- R7: A freeze caused by the peer raises no request. After a request is dropped, `req_o` stays low. It stays low while `peer_ack_i` falls back.
- R8: `ack_o` follows `peer_req_i` with a one-cycle delay. It rises after the request rises and falls after it falls.
- R9: A `release_i` pulse while frozen and idle clears `frozen_o` and sets `cause_o` to 2'b00 at the next edge. Idle means `req_o`, `peer_req_i` and `ack_o` are low and no request is waiting for `peer_ack_i` to fall.
- R10: `release_i` has no effect while any handshake is in progress.
- R11: During reset, `frozen_o`, `req_o` and `ack_o` are low and `cause_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_err_i | input | NUM_SYNC | Loss-of-sync strobes from monitors |
| eev_err_i | input | NUM_EEV | End-event tag mismatch strobes, one per bus |
| wr_req_i | input | LANES | Buffer write requests |
| release_i | input | 1 | Software release pulse |
| peer_req_i | input | 1 | Freeze request from peer controller |
| peer_code_i | input | 2 | Peer's reason code (observed only) |
| peer_ack_i | input | 1 | Peer acknowledge of local request |
| wr_en_o | output | LANES | Gated buffer write enables |
| frozen_o | output | 1 | Freeze active |
| cause_o | output | 2 | Latched reason code |
| req_o | output | 1 | Freeze request to peer |
| req_code_o | output | 2 | Reason code sent with the request |
| ack_o | output | 1 | Acknowledge to peer request |

## Verification
Several properties are checked on every cycle:
- Write gating while frozen.
- The request being held until acknowledged and dropped after it.
- The acknowledge tracking the peer request.
- A freeze holding its code until released.
- Release being blocked during a handshake.
- The absence of a request for a peer-caused freeze.

The cause priority among simultaneous triggers, the gating in the trigger cycle itself, and a successful release need the bench. The bench sweeps every combination of sync, end-event and peer triggers from the idle state. It then walks each freeze through the full handshake and release.

// File: rtl/spy_freeze_pkg.sv
package spy_freeze_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_SYNC = 2'b01,
    CAUSE_EEV  = 2'b10,
    CAUSE_PEER = 2'b11
  } cause_e;

  typedef enum logic [1:0] {
    HS_IDLE = 2'b00,
    HS_REQ  = 2'b01,
    HS_WAIT = 2'b10
  } hs_state_e;
endpackage

// File: rtl/freeze_cause_sel.sv
module freeze_cause_sel
  import spy_freeze_pkg::*;
#(
  parameter int NUM_SYNC = 4,
  parameter int NUM_EEV  = 12
) (
  input  logic [NUM_SYNC-1:0] sync_err_i,
  input  logic [NUM_EEV-1:0]  eev_err_i,
  input  logic                peer_req_i,
  output logic                hit_o,
  output logic                local_o,
  output cause_e              cause_o
);
  logic any_sync, any_eev;

  assign any_sync = |sync_err_i;
  assign any_eev  = |eev_err_i;
  assign local_o  = any_sync | any_eev;
  assign hit_o    = local_o | peer_req_i;

  // priority: sync loss > end-event > peer
  always_comb begin
    if (any_sync)        cause_o = CAUSE_SYNC;
    else if (any_eev)    cause_o = CAUSE_EEV;
    else if (peer_req_i) cause_o = CAUSE_PEER;
    else                 cause_o = CAUSE_NONE;
  end
endmodule

// File: rtl/freeze_req_initiator.sv
module freeze_req_initiator
  import spy_freeze_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] code_i,
  input  logic       peer_ack_i,
  output logic       req_o,
  output logic [1:0] req_code_o,
  output logic       busy_o
);
  hs_state_e state_q, state_d;
  logic [1:0] code_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE: if (start_i)     state_d = HS_REQ;
      HS_REQ:  if (peer_ack_i)  state_d = HS_WAIT;
      HS_WAIT: if (!peer_ack_i) state_d = HS_IDLE;
      default:                  state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      code_q  <= 2'b00;
    end else begin
      state_q <= state_d;
      if (state_q == HS_IDLE && start_i) code_q <= code_i;
    end
  end

  assign req_o      = (state_q == HS_REQ);
  assign req_code_o = req_o ? code_q : 2'b00;
  assign busy_o     = (state_q != HS_IDLE);
endmodule

// File: rtl/freeze_ack_responder.sv
module freeze_ack_responder (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic peer_req_i,
  output logic ack_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_o <= 1'b0;
    else         ack_o <= peer_req_i;
  end
endmodule

// File: rtl/freeze_wr_gate.sv
module freeze_wr_gate #(
  parameter int LANES = 12
) (
  input  logic             block_i,
  input  logic [LANES-1:0] wr_req_i,
  output logic [LANES-1:0] wr_en_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_en_o[g] = wr_req_i[g] & ~block_i;
  end
endmodule

// File: rtl/spy_freeze_ctrl.sv
module spy_freeze_ctrl
  import spy_freeze_pkg::*;
#(
  parameter int NUM_SYNC = 4,
  parameter int NUM_EEV  = 12,
  parameter int LANES    = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SYNC-1:0] sync_err_i,
  input  logic [NUM_EEV-1:0]  eev_err_i,
  input  logic [LANES-1:0]    wr_req_i,
  input  logic                release_i,
  input  logic                peer_req_i,
  input  logic [1:0]          peer_code_i,
  input  logic                peer_ack_i,
  output logic [LANES-1:0]    wr_en_o,
  output logic                frozen_o,
  output logic [1:0]          cause_o,
  output logic                req_o,
  output logic [1:0]          req_code_o,
  output logic                ack_o
);
  logic   hit, local_hit, trig, init_busy, busy, do_release;
  logic   frozen_q;
  cause_e sel_cause, cause_q;
  logic   unused_peer_code;

  assign unused_peer_code = ^peer_code_i;

  freeze_cause_sel #(.NUM_SYNC(NUM_SYNC), .NUM_EEV(NUM_EEV)) u_sel (
    .sync_err_i (sync_err_i),
    .eev_err_i  (eev_err_i),
    .peer_req_i (peer_req_i),
    .hit_o      (hit),
    .local_o    (local_hit),
    .cause_o    (sel_cause)
  );

  assign trig       = hit & ~frozen_q;
  assign busy       = init_busy | peer_req_i | ack_o;
  assign do_release = frozen_q & release_i & ~busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end else if (trig) begin
      frozen_q <= 1'b1;
      cause_q  <= sel_cause;
    end else if (do_release) begin
      frozen_q <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end
  end

  freeze_req_initiator u_init (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (trig & local_hit),
    .code_i     (sel_cause),
    .peer_ack_i (peer_ack_i),
    .req_o      (req_o),
    .req_code_o (req_code_o),
    .busy_o     (init_busy)
  );

  freeze_ack_responder u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .peer_req_i (peer_req_i),
    .ack_o      (ack_o)
  );

  freeze_wr_gate #(.LANES(LANES)) u_gate (
    .block_i  (frozen_q | hit),
    .wr_req_i (wr_req_i),
    .wr_en_o  (wr_en_o)
  );

  assign frozen_o = frozen_q;
  assign cause_o  = cause_q;
endmodule

// File: rtl/spy_freeze_ctrl_chk.sv
module spy_freeze_ctrl_chk #(
  parameter int LANES = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LANES-1:0] wr_en_o,
  input logic             frozen_o,
  input logic [1:0]       cause_o,
  input logic             req_o,
  input logic             ack_o,
  input logic             peer_req_i,
  input logic             peer_ack_i,
  input logic             release_i
);
  assert_gate_closed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o |-> (wr_en_o == '0));

  assert_code_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o == (cause_o != 2'b00));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o && !release_i |=> frozen_o && $stable(cause_o));

  assert_req_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !peer_ack_i |=> req_o);

  assert_req_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && peer_ack_i |=> !req_o);

  assert_peer_noreq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o == 2'b11) |-> !req_o);

  assert_ack_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peer_req_i |=> ack_o);

  assert_ack_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !peer_req_i |=> !ack_o);

  assert_rel_block_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o && (req_o || peer_req_i || ack_o) |=> frozen_o);
endmodule

bind spy_freeze_ctrl spy_freeze_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_o    (wr_en_o),
  .frozen_o   (frozen_o),
  .cause_o    (cause_o),
  .req_o      (req_o),
  .ack_o      (ack_o),
  .peer_req_i (peer_req_i),
  .peer_ack_i (peer_ack_i),
  .release_i  (release_i)
);

// File: tb/spy_freeze_ctrl_tb.sv
`timescale 1ns/1ps
module spy_freeze_ctrl_tb;
  localparam int NS = 2;
  localparam int NE = 2;
  localparam int NL = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] sync_err_i = '0;
  logic [NE-1:0] eev_err_i = '0;
  logic [NL-1:0] wr_req_i = '0;
  logic          release_i = 1'b0;
  logic          peer_req_i = 1'b0;
  logic [1:0]    peer_code_i = 2'b00;
  logic          peer_ack_i = 1'b0;
  logic [NL-1:0] wr_en_o;
  logic          frozen_o;
  logic [1:0]    cause_o;
  logic          req_o;
  logic [1:0]    req_code_o;
  logic          ack_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  spy_freeze_ctrl #(.NUM_SYNC(NS), .NUM_EEV(NE), .LANES(NL)) u_dut (
    .clk_i, .rst_ni, .sync_err_i, .eev_err_i, .wr_req_i, .release_i,
    .peer_req_i, .peer_code_i, .peer_ack_i, .wr_en_o, .frozen_o, .cause_o,
    .req_o, .req_code_o, .ack_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick();
    chk("R11 frozen", frozen_o, 0);
    chk("R11 cause", cause_o, 0);
    chk("R11 req", req_o, 0);
    chk("R11 ack", ack_o, 0);
    tick();
    rst_ni = 1'b1;
    tick();
    for (int c = 0; c < 32; c++) begin
      int exp_c;
      bit is_local;
      exp_c = (c[1:0] != 0) ? 1 : (c[3:2] != 0) ? 2 : c[4] ? 3 : 0;
      is_local = (exp_c == 1) || (exp_c == 2);
      sync_err_i = c[1:0];
      eev_err_i  = c[3:2];
      peer_req_i = c[4];
      peer_code_i = 2'(c);
      wr_req_i   = NL'(c | 1);
      #1;
      chk("R1 trigger-cycle gate", wr_en_o, exp_c != 0 ? 0 : (c | 1) & 7);
      tick();
      sync_err_i = '0;
      eev_err_i  = '0;
      #1;
      chk("R2 R3 R4 frozen", frozen_o, exp_c != 0);
      chk("R2 R3 R4 cause", cause_o, exp_c);
      chk("R6 R7 req", req_o, is_local);
      chk("R6 req_code", req_code_o, is_local ? exp_c : 0);
      chk("R8 ack rise", ack_o, c[4]);
      if (exp_c == 0) begin
        wr_req_i = '0;
        continue;
      end
      chk("R1 frozen gate", wr_en_o, 0);
      sync_err_i = '1;
      eev_err_i  = '1;
      tick();
      sync_err_i = '0;
      eev_err_i  = '0;
      #1;
      chk("R5 cause kept", cause_o, exp_c);
      chk("R5 frozen kept", frozen_o, 1);
      release_i = 1'b1;
      tick();
      release_i = 1'b0;
      chk("R10 release ignored early", frozen_o, 1);
      chk("R6 req held", req_o, is_local);
      peer_ack_i = 1'b1;
      tick();
      chk("R6 req dropped", req_o, 0);
      release_i = 1'b1;
      tick();
      release_i = 1'b0;
      chk("R10 release ignored mid", frozen_o, 1);
      peer_ack_i = 1'b0;
      peer_req_i = 1'b0;
      tick();
      chk("R8 ack fall", ack_o, 0);
      chk("R7 no re-request", req_o, 0);
      release_i = 1'b1;
      tick();
      release_i = 1'b0;
      chk("R9 unfrozen", frozen_o, 0);
      chk("R9 cause cleared", cause_o, 0);
      chk("R1 reopened", wr_en_o, (c | 1) & 7);
      wr_req_i = '0;
      tick();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule